// File: doc/BRIEF.md
# Delay-Slot Branch Next-PC Resolver

When an instruction traps or faults while sitting in the delay slot of a branch, simply stepping the program counter by one instruction would skip the branch's effect. This unit takes the address of that branch, its 32-bit instruction word, a flag saying whether the trap happened in a delay slot, and the current condition flag. It re-evaluates the branch and produces the address at which execution must resume. For the linking forms, it also produces the write to the link register that the branch would have made.

The major opcode sits in instruction bits [31:26]. Six forms redirect:
- 0x00 jumps PC-relative.
- 0x01 jumps PC-relative and links.
- 0x04 branches when the flag is set.
- 0x03 branches when the flag is clear.
- 0x11 jumps through a register.
- 0x12 jumps through a register and links.

The unit reads the register file through a combinational read port: it presents an index and receives the data in the same cycle. Results are captured into an output register behind a valid/ready handshake.

Top module: `dslot_resolver`

## Requirements
- R1: When in_dslot is 0, the result is cur_pc + 4 with link_we = 0, whatever the opcode and flag.
- R2: In a delay slot, opcode 0x00 resumes at cur_pc + D. D is insn[25:0] shifted left by 2 and sign-extended from bit 27 to 32 bits. The addition wraps modulo 2^32, and link_we = 0.
- R3: In a delay slot, opcode 0x01 resumes at cur_pc + D and writes link register 9 (link_idx = 9) with that resume address + 8.
- R4: In a delay slot, opcode 0x04 resumes at cur_pc + D when cond_flag is 1 and at cur_pc + 8 otherwise. Opcode 0x03 does the reverse. Neither links.
- R5: rf_raddr always equals insn[15:11]. In a delay slot, opcode 0x11 resumes at the value read from that register, with no link.
- R6: In a delay slot, opcode 0x12 resumes at the register value and writes register 9 with that address + 8.
- R7: A register read of index 0 yields zero for the indirect forms, whatever rf_rdata carries.
- R8: In a delay slot, any opcode other than the six above resumes at cur_pc + 4 with link_we = 0.
- R9: in_ready is 1 when out_valid is 0 or out_ready is 1. While out_valid is 1 and out_ready is 0, the outputs hold and a new input is not taken. A pending result leaves once out_ready is seen, and the next input is taken in that same cycle.
- R10: A synchronous active-high rst clears out_valid at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when in_valid is 1 |
| cur_pc | input | 32 | Address of the branch instruction |
| insn | input | 32 | Branch instruction word |
| in_dslot | input | 1 | Trap occurred in the delay slot |
| cond_flag | input | 1 | Condition flag |
| rf_raddr | output | 5 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (same cycle) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts result |
| next_pc | output | 32 | Resume address |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index |
| link_data | output | 32 | Link register write value |

## Verification
The hardest cases to reach are a negative displacement that carries the resume address through the top of the address space, and an indirect jump through register 0 while the read port returns non-zero data. The stimulus sweeps all 64 opcodes against both delay-slot and flag values. It uses instruction patterns with positive, negative and zero displacement. Some program counters are placed just below the wrap point. The bench's register model returns non-zero data for every index, so the zero forcing is visible. A separate sequence holds out_ready low across a new request, then releases it to show the pending result leaving and the new request being taken in one cycle.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;
  localparam int OPC_W  = 6;
  localparam int IMM_W  = 26;
  localparam int ILEN   = 4;

  localparam logic [OPC_W-1:0] OPC_JMP     = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JMP_LNK = 6'h01;
  localparam logic [OPC_W-1:0] OPC_BR_CLR  = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BR_SET  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_IND     = 6'h11;
  localparam logic [OPC_W-1:0] OPC_IND_LNK = 6'h12;

  typedef enum logic [2:0] {
    K_STEP,
    K_JUMP,
    K_JUMP_LINK,
    K_BRANCH,
    K_REG,
    K_REG_LINK
  } kind_e;

  typedef struct packed {
    logic [XLEN-1:0]   pc;
    logic              lwe;
    logic [RIDX_W-1:0] lidx;
    logic [XLEN-1:0]   ldata;
  } result_t;

  function automatic kind_e classify(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_JMP:              return K_JUMP;
      OPC_JMP_LNK:          return K_JUMP_LINK;
      OPC_BR_CLR, OPC_BR_SET: return K_BRANCH;
      OPC_IND:              return K_REG;
      OPC_IND_LNK:          return K_REG_LINK;
      default:              return K_STEP;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] rel_target(input logic [XLEN-1:0] pc,
                                                 input logic [IMM_W-1:0] imm);
    logic signed [XLEN-1:0] d;
    d = $signed({imm, {(XLEN-IMM_W){1'b0}}}) >>> (XLEN - IMM_W - 2);
    return pc + d;
  endfunction

  function automatic logic [XLEN-1:0] step_pc(input logic [XLEN-1:0] pc,
                                              input int unsigned n);
    return pc + XLEN'(n * ILEN);
  endfunction

  function automatic logic [XLEN-1:0] link_value(input logic [XLEN-1:0] tgt);
    return tgt + XLEN'(2 * ILEN);
  endfunction

endpackage

// File: rtl/dsr_decode.sv
module dsr_decode
  import dsr_pkg::*;
(
  input  logic [OPC_W-1:0]  opc,
  input  logic              in_dslot,
  input  logic              cond_flag,
  output kind_e             kind,
  output logic              taken
);

  kind_e raw_kind;

  always_comb begin
    raw_kind = classify(opc);
    kind     = in_dslot ? raw_kind : K_STEP;
    // 0x04 follows the flag, 0x03 inverts it
    taken    = (opc == OPC_BR_SET) ? cond_flag : !cond_flag;
  end

  // R8: unknown opcodes never classify as a redirect
  always_comb begin
    if (opc != OPC_JMP && opc != OPC_JMP_LNK && opc != OPC_BR_CLR &&
        opc != OPC_BR_SET && opc != OPC_IND && opc != OPC_IND_LNK)
      p_other_step_r8: assert (kind == K_STEP);
  end

endmodule

// File: rtl/dsr_target.sv
module dsr_target
  import dsr_pkg::*;
#(
  parameter int LINK_REG = 9
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [RIDX_W-1:0] src_idx,
  input  logic [XLEN-1:0]   rf_rdata,
  input  kind_e             kind,
  input  logic              taken,
  output result_t           res
);

  logic [XLEN-1:0] rel_pc;
  logic [XLEN-1:0] reg_val;
  logic [XLEN-1:0] nxt;
  logic            want_link;
  logic            link_en;

  assign rel_pc  = rel_target(pc, imm);
  // register 0 reads as zero
  assign reg_val = (src_idx == '0) ? '0 : rf_rdata;

  always_comb begin
    want_link = 1'b0;
    case (kind)
      K_JUMP:      nxt = rel_pc;
      K_JUMP_LINK: begin nxt = rel_pc; want_link = 1'b1; end
      K_BRANCH:    nxt = taken ? rel_pc : step_pc(pc, 2);
      K_REG:       nxt = reg_val;
      K_REG_LINK:  begin nxt = reg_val; want_link = 1'b1; end
      default:     nxt = step_pc(pc, 1);
    endcase
  end

  // writes to register 0 are dropped
  generate
    if (LINK_REG == 0) begin : g_nolink
      assign link_en = 1'b0;
    end else begin : g_link
      assign link_en = want_link;
    end
  endgenerate

  always_comb begin
    res.pc    = nxt;
    res.lwe   = link_en;
    res.lidx  = RIDX_W'(LINK_REG);
    res.ldata = link_value(nxt);
  end

  // R1: a plain step never links and always advances one instruction
  always_comb begin
    if (kind == K_STEP)
      p_step_plain_r1: assert (!res.lwe && res.pc == pc + XLEN'(ILEN));
  end

endmodule

// File: rtl/dsr_outreg.sv
module dsr_outreg
  import dsr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    in_valid,
  output logic    in_ready,
  input  result_t res_d,
  output logic    out_valid,
  input  logic    out_ready,
  output result_t res_q
);

  logic    v_q;
  logic    load;

  assign in_ready  = !v_q || out_ready;
  assign load      = in_valid && in_ready;
  assign out_valid = v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
    end else if (load) begin
      v_q <= 1'b1;
    end else if (out_ready) begin
      v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) res_q <= res_d;
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(res_q));

  p_load_src_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid));

  p_link_data_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && res_q.lwe |-> res_q.ldata == res_q.pc + XLEN'(2 * ILEN));

endmodule

// File: rtl/dslot_resolver.sv
module dslot_resolver
  import dsr_pkg::*;
#(
  parameter int LINK_REG = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   insn,
  input  logic              in_dslot,
  input  logic              cond_flag,
  output logic [RIDX_W-1:0] rf_raddr,
  input  logic [XLEN-1:0]   rf_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   next_pc,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_data
);

  kind_e   kind;
  logic    taken;
  result_t res_d;
  result_t res_q;

  assign rf_raddr = insn[15:11];

  dsr_decode u_dec (
    .opc       (insn[31:26]),
    .in_dslot  (in_dslot),
    .cond_flag (cond_flag),
    .kind      (kind),
    .taken     (taken)
  );

  dsr_target #(.LINK_REG(LINK_REG)) u_tgt (
    .pc       (cur_pc),
    .imm      (insn[25:0]),
    .src_idx  (rf_raddr),
    .rf_rdata (rf_rdata),
    .kind     (kind),
    .taken    (taken),
    .res      (res_d)
  );

  dsr_outreg u_reg (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .res_d     (res_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .res_q     (res_q)
  );

  assign next_pc   = res_q.pc;
  assign link_we   = out_valid && res_q.lwe;
  assign link_idx  = res_q.lidx;
  assign link_data = res_q.ldata;

  p_link_idx_r3: assert property (@(posedge clk) disable iff (rst)
    link_we |-> link_idx == RIDX_W'(LINK_REG));

endmodule

// File: tb/sim_dslot_resolver.sv
`timescale 1ns/1ps
module sim_dslot_resolver;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready;
  logic [31:0] cur_pc, insn;
  logic        in_dslot, cond_flag;
  logic [4:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        out_valid, out_ready;
  logic [31:0] next_pc;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [31:0] link_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  // register model: every index returns non-zero data
  assign rf_rdata = {rf_raddr, 3'b101, 8'h3C, rf_raddr, 3'b010, 8'hC3};

  dslot_resolver u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .cur_pc(cur_pc), .insn(insn), .in_dslot(in_dslot), .cond_flag(cond_flag),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .out_valid(out_valid),
    .out_ready(out_ready), .next_pc(next_pc), .link_we(link_we),
    .link_idx(link_idx), .link_data(link_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_reg(input logic [4:0] i);
    if (i == 5'd0) return 32'd0;
    return {i, 3'b101, 8'h3C, i, 3'b010, 8'hC3};
  endfunction

  function automatic string req_of(input logic [5:0] op, input bit ds);
    if (!ds) return "R1";
    case (op)
      6'h00: return "R2";
      6'h01: return "R3";
      6'h03, 6'h04: return "R4";
      6'h11: return "R5";
      6'h12: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic send_and_check(input logic [31:0] pc, input logic [31:0] iw,
                                input bit ds, input bit fl);
    logic [31:0] disp, exp_pc;
    bit          exp_lnk;
    string       rq;
    disp    = {{4{iw[25]}}, iw[25:0], 2'b00};
    exp_lnk = 1'b0;
    exp_pc  = pc + 32'd4;
    if (ds) begin
      case (iw[31:26])
        6'h00: exp_pc = pc + disp;
        6'h01: begin exp_pc = pc + disp; exp_lnk = 1'b1; end
        6'h04: exp_pc = fl ? pc + disp : pc + 32'd8;
        6'h03: exp_pc = fl ? pc + 32'd8 : pc + disp;
        6'h11: exp_pc = model_reg(iw[15:11]);
        6'h12: begin exp_pc = model_reg(iw[15:11]); exp_lnk = 1'b1; end
        default: exp_pc = pc + 32'd4;
      endcase
    end
    rq = req_of(iw[31:26], ds);
    if (ds && (iw[31:26] == 6'h11 || iw[31:26] == 6'h12) && iw[15:11] == 5'd0)
      rq = "R7";
    @(negedge clk);
    cur_pc = pc; insn = iw; in_dslot = ds; cond_flag = fl;
    in_valid = 1'b1; out_ready = 1'b1;
    #1;
    check(rf_raddr == iw[15:11], "R5", "rf_raddr", {27'd0, rf_raddr}, {27'd0, iw[15:11]});
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R9", "out_valid", {31'd0, out_valid}, 32'd1);
    check(next_pc == exp_pc, rq, "next_pc", next_pc, exp_pc);
    check(link_we == exp_lnk, rq, "link_we", {31'd0, link_we}, {31'd0, exp_lnk});
    if (exp_lnk) begin
      check(link_idx == 5'd9, rq, "link_idx", {27'd0, link_idx}, 32'd9);
      check(link_data == exp_pc + 32'd8, rq, "link_data", link_data, exp_pc + 32'd8);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [25:0] pat [3];
    logic [31:0] hold_pc;
    pat[0] = 26'h0000000;
    pat[1] = 26'h0155A37;
    pat[2] = 26'h2ABCDEF;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    cur_pc = '0; insn = '0; in_dslot = 1'b0; cond_flag = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check(out_valid == 1'b0, "R10", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R9", "in_ready idle", {31'd0, in_ready}, 32'd1);

    // sweep all opcodes, delay-slot and flag values, displacement patterns
    for (int op = 0; op < 64; op++)
      for (int ds = 0; ds < 2; ds++)
        for (int fl = 0; fl < 2; fl++)
          for (int v = 0; v < 3; v++) begin
            logic [31:0] pc;
            // pattern 1 sits near the top to force wrap-around (R2)
            pc = (v == 1) ? 32'hFFFF_FFF0 - 32'(op) * 4 : 32'h0010_0000 + 32'(op) * 16 + 32'(v) * 4;
            send_and_check(pc, {6'(op), pat[v]}, ds[0], fl[0]);
          end

    // R2: large negative displacement wrapping below zero
    send_and_check(32'h0000_0010, {6'h00, 26'h3FFFFF0}, 1'b1, 1'b0);

    // R9: back-pressure
    @(negedge clk);
    cur_pc = 32'h0000_2000; insn = {6'h00, 26'h0000040}; in_dslot = 1'b1; cond_flag = 1'b0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    hold_pc = 32'h0000_2100;
    check(next_pc == hold_pc, "R9", "captured pc", next_pc, hold_pc);
    cur_pc = 32'h0000_3000; insn = {6'h3F, 26'h0};
    for (int k = 0; k < 3; k++) begin
      #1;
      check(in_ready == 1'b0, "R9", "in_ready stalled", {31'd0, in_ready}, 32'd0);
      @(negedge clk);
      check(out_valid == 1'b1 && next_pc == hold_pc, "R9", "held pc", next_pc, hold_pc);
    end
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R9", "in_ready released", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    check(out_valid == 1'b1 && next_pc == 32'h0000_3004, "R9", "second taken", next_pc, 32'h0000_3004);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "drained", {31'd0, out_valid}, 32'd0);

    // R10: reset while a result is pending
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R10", "pending before reset", {31'd0, out_valid}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0, "R10", "cleared by reset", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule